// File: doc/BRIEF.md
# Streaming Single-Pass Blob Labeler

This block watches a raster-ordered colour pixel stream and finds its connected foreground regions without storing a labelled copy of the image. Every pixel is first compared against a per-channel colour floor. A pixel that passes is foreground. It takes a label from its left neighbour or its upper neighbour, or it starts a new label. The labels of the row above come out of a shift-register line buffer that is exactly one row long. When two different labels touch, an equivalence entry ties the higher label to the lower one. While the pixels stream past, each pixel's area count and its X and Y coordinate sums go straight into the table entry of its resolved label.

Once the last pixel of the last row has arrived, a short sequencer runs. It first folds every label's counters into the root label found through the equivalence table. It then visits each root label in turn and runs two restoring dividers side by side, which give the floor of the mean X and the floor of the mean Y. A query port returns the area and centroid of any label index once the results-ready flag is high. A new frame start throws away all previous results.

Top module: `blob_labeler`

## Requirements
- R1: A pixel is foreground only when each of its three colour channels (red in the top CH_W bits, then green, then blue in the low bits) is greater than or equal to the matching channel of FG_MIN. A channel that equals its floor counts as passing.
- R2: Connectivity is 4-way (left and up). Pixels that touch only diagonally belong to different blobs.
- R3: New labels are handed out as 1, 2, 3, … in raster order. A blob is reported under the label of its first pixel in raster order. A label index that is unused, absorbed into another label, or above MAX_LABELS reports queryHit low.
- R4: When two labels meet, the blob is reported once, under the lower label, and the higher label reports zero area.
- R5: A reported blob's area equals its number of foreground pixels. A pixel that joins two labels is counted once.
- R6: The centroid of a reported blob is floor(sum of X / area) and floor(sum of Y / area). X counts from 0 at the start of each line, and Y counts from 0 at frame start.
- R7: If a frame needs more than MAX_LABELS new labels, overflowErr is set and stays set until the next frame start clears it. A frame that needs exactly MAX_LABELS labels does not set it.
- R8: resultsReady is low while a frame streams in and goes high after the per-label results are complete. labelDone pulses exactly once per reported blob.
- R9: After reset, resultsReady, overflowErr and queryHit are low.
- R10: A pixel marked as frame start discards all results of the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pixValid | input | 1 | Pixel qualifier |
| pixData | input | PIX_W | Packed colour pixel, red in the top bits |
| frameStart | input | 1 | Marks the first pixel of a frame |
| lineEnd | input | 1 | Marks the last pixel of a line |
| queryIdx | input | LBL_W | Label index to read |
| queryHit | output | 1 | Queried label is a reported blob |
| queryArea | output | AREA_W | Pixel count of the queried label |
| queryCx | output | XW | Centroid X of the queried label |
| queryCy | output | YW | Centroid Y of the queried label |
| resultsReady | output | 1 | Results of the last frame are complete |
| labelDone | output | 1 | One-cycle strobe per finished blob |
| overflowErr | output | 1 | Sticky label-overflow flag for this frame |

## Verification
The bench uses a U shape and a comb with four teeth. These force the equivalence table to tie labels together, and the comb ties several of them in a chain. A design that lost an equivalence would split these blobs, and one that added counters twice would report too large an area. A diagonal staircase tests 4-way connectivity, where an 8-way design would merge the steps into one blob. A frame that needs exactly MAX_LABELS labels and a checkerboard that needs far more test the allocator limit, where an off-by-one design would raise the overflow flag too early or too late. Pixels set exactly at the colour floor, or just below it, test the threshold comparison. An empty frame sent after a busy one shows whether stale labels survive a frame start.

// File: rtl/blob_pkg.sv
package blob_pkg;
  typedef struct packed {
    logic foldEn;
    logic divStart;
    logic divCapture;
  } ctl_t;

  typedef enum logic [2:0] {
    ST_STREAM, ST_FOLD, ST_PICK, ST_WAIT, ST_READY
  } phase_t;
endpackage

// File: rtl/blob_divider.sv
module blob_divider #(
  parameter int NUM_W = 10,
  parameter int DEN_W = 7,
  parameter int OUT_W = 3,
  parameter int CNT_W = $clog2(NUM_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [OUT_W-1:0] quot,
  output logic             done
);
  logic [NUM_W-1:0] q, numHold;
  logic [DEN_W-1:0] rem, denHold;
  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic [DEN_W:0]   shifted, trial;

  always_comb begin
    shifted = {rem, q[NUM_W-1]};
    trial   = shifted - {1'b0, denHold};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q <= '0; numHold <= '0; rem <= '0; denHold <= '0;
      cnt <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q <= num; numHold <= num; denHold <= den;
        rem <= '0; cnt <= CNT_W'(NUM_W); busy <= 1'b1;
      end else if (busy) begin
        if (!trial[DEN_W]) begin
          rem <= trial[DEN_W-1:0];
          q   <= {q[NUM_W-2:0], 1'b1};
        end else begin
          rem <= shifted[DEN_W-1:0];
          q   <= {q[NUM_W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = q[OUT_W-1:0];

  // R6: a finished quotient never overshoots and the remainder is below the divisor
  assert_quotient_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (({{DEN_W{1'b0}}, q} * {{NUM_W{1'b0}}, denHold}) <= {{DEN_W{1'b0}}, numHold})
             && (rem < denHold));
endmodule

// File: rtl/blob_control.sv
module blob_control
  import blob_pkg::*;
#(
  parameter int MAX_LABELS = 8,
  parameter int LBL_W      = $clog2(MAX_LABELS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic             frameStart,
  input  logic             frameEnd,
  input  logic             idxArea,
  input  logic             divDone,
  output ctl_t             ctl,
  output logic [LBL_W-1:0] idx,
  output logic             resultsReady,
  output logic             labelDone
);
  phase_t st;
  logic   lastIdx;

  assign lastIdx = (idx == LBL_W'(MAX_LABELS));

  always_comb begin
    ctl            = '0;
    ctl.foldEn     = (st == ST_FOLD);
    ctl.divStart   = (st == ST_PICK) && idxArea;
    ctl.divCapture = (st == ST_WAIT) && divDone;
  end

  assign labelDone    = ctl.divCapture;
  assign resultsReady = (st == ST_READY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= ST_STREAM;
      idx <= LBL_W'(1);
    end else if (pixValid && frameStart) begin
      st <= ST_STREAM;
    end else begin
      case (st)
        ST_STREAM: if (frameEnd) begin st <= ST_FOLD; idx <= LBL_W'(1); end
        ST_FOLD:   if (lastIdx) begin st <= ST_PICK; idx <= LBL_W'(1); end
                   else idx <= idx + 1'b1;
        ST_PICK:   if (idxArea) st <= ST_WAIT;
                   else if (lastIdx) st <= ST_READY;
                   else idx <= idx + 1'b1;
        ST_WAIT:   if (divDone) begin
                     if (lastIdx) st <= ST_READY;
                     else begin idx <= idx + 1'b1; st <= ST_PICK; end
                   end
        default:   st <= st;
      endcase
    end
  end

  // R8: a blob is only finished for a label that owns pixels
  assert_capture_has_area_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.divCapture |-> idxArea);
  // R8: results stay ready until a new frame begins
  assert_ready_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    resultsReady && !(pixValid && frameStart) |=> resultsReady);
endmodule

// File: rtl/blob_datapath.sv
module blob_datapath
  import blob_pkg::*;
#(
  parameter int IMG_W      = 8,
  parameter int IMG_H      = 8,
  parameter int MAX_LABELS = 8,
  parameter int PIX_W      = 12,
  parameter logic [PIX_W-1:0] FG_MIN = 12'h888,
  parameter int LBL_W  = $clog2(MAX_LABELS + 1),
  parameter int XW     = $clog2(IMG_W),
  parameter int YW     = $clog2(IMG_H),
  parameter int AREA_W = $clog2(IMG_W * IMG_H + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  logic [PIX_W-1:0]  pixData,
  input  logic              frameStart,
  input  logic              lineEnd,
  input  ctl_t              ctl,
  input  logic [LBL_W-1:0]  idx,
  input  logic [LBL_W-1:0]  queryIdx,
  output logic              frameEnd,
  output logic              idxArea,
  output logic              divDone,
  output logic [AREA_W-1:0] queryArea,
  output logic [XW-1:0]     queryCx,
  output logic [YW-1:0]     queryCy,
  output logic              overflow
);
  localparam int CNT_W = LBL_W + 1;
  localparam int CRD_W = (XW > YW) ? XW : YW;
  localparam int SUM_W = CRD_W + AREA_W;
  localparam int CH_W  = PIX_W / 3;
  localparam int NLBL  = MAX_LABELS + 1;

  logic [LBL_W-1:0]  mergeTab [NLBL];
  logic [AREA_W-1:0] area     [NLBL];
  logic [SUM_W-1:0]  sumX     [NLBL];
  logic [SUM_W-1:0]  sumY     [NLBL];
  logic [XW-1:0]     cenX     [NLBL];
  logic [YW-1:0]     cenY     [NLBL];
  logic [LBL_W-1:0]  lineBuf  [IMG_W];

  logic [XW-1:0]    xPos, curX;
  logic [YW-1:0]    yPos, curY;
  logic [LBL_W-1:0] westLbl, westRaw, northRaw, rootW, rootN, loL, hiL, pixLbl, foldRoot;
  logic [CNT_W-1:0] nextLbl, allocNext;
  logic             isFg, canAlloc, newNeed, mergeNeed, doneX, doneY;
  logic [XW-1:0]    qX;
  logic [YW-1:0]    qY;

  always_comb begin
    isFg = (pixData[PIX_W-1 -: CH_W]  >= FG_MIN[PIX_W-1 -: CH_W]) &&
           (pixData[2*CH_W-1 -: CH_W] >= FG_MIN[2*CH_W-1 -: CH_W]) &&
           (pixData[CH_W-1:0]         >= FG_MIN[CH_W-1:0]);
    curX     = frameStart ? '0 : xPos;
    curY     = frameStart ? '0 : yPos;
    westRaw  = (curX == '0) ? '0 : westLbl;
    northRaw = (curY == '0) ? '0 : lineBuf[IMG_W-1];
    rootW    = westRaw;
    rootN    = northRaw;
    foldRoot = idx;
    for (int k = 0; k < MAX_LABELS; k++) begin
      rootW    = mergeTab[rootW];
      rootN    = mergeTab[rootN];
      foldRoot = mergeTab[foldRoot];
    end
    loL       = (rootW < rootN) ? rootW : rootN;
    hiL       = (rootW < rootN) ? rootN : rootW;
    allocNext = frameStart ? CNT_W'(1) : nextLbl;
    canAlloc  = allocNext <= CNT_W'(MAX_LABELS);
    newNeed   = isFg && (rootW == '0) && (rootN == '0);
    mergeNeed = isFg && (rootW != '0) && (rootN != '0) && (rootW != rootN);
    if (!isFg)              pixLbl = '0;
    else if (newNeed)       pixLbl = canAlloc ? allocNext[LBL_W-1:0] : '0;
    else if (rootW == '0)   pixLbl = rootN;
    else if (rootN == '0)   pixLbl = rootW;
    else                    pixLbl = loL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xPos <= '0; yPos <= '0; westLbl <= '0; nextLbl <= CNT_W'(1);
      overflow <= 1'b0; frameEnd <= 1'b0;
      for (int i = 0; i < NLBL; i++) begin
        mergeTab[i] <= LBL_W'(i);
        area[i] <= '0; sumX[i] <= '0; sumY[i] <= '0; cenX[i] <= '0; cenY[i] <= '0;
      end
      for (int j = 0; j < IMG_W; j++) lineBuf[j] <= '0;
    end else begin
      frameEnd <= pixValid && lineEnd && (curY == YW'(IMG_H - 1));
      if (ctl.foldEn && (foldRoot != idx)) begin
        area[foldRoot] <= area[foldRoot] + area[idx];
        sumX[foldRoot] <= sumX[foldRoot] + sumX[idx];
        sumY[foldRoot] <= sumY[foldRoot] + sumY[idx];
        area[idx] <= '0; sumX[idx] <= '0; sumY[idx] <= '0;
      end
      if (ctl.divCapture) begin
        cenX[idx] <= qX;
        cenY[idx] <= qY;
      end
      if (pixValid) begin
        if (frameStart) begin
          overflow <= 1'b0;
          for (int i = 0; i < NLBL; i++) begin
            mergeTab[i] <= LBL_W'(i);
            area[i] <= '0; sumX[i] <= '0; sumY[i] <= '0;
          end
        end
        if (newNeed && !canAlloc) overflow <= 1'b1;
        if (lineEnd) begin xPos <= '0; yPos <= curY + 1'b1; end
        else begin xPos <= curX + 1'b1; yPos <= curY; end
        westLbl    <= pixLbl;
        lineBuf[0] <= pixLbl;
        for (int j = 1; j < IMG_W; j++) lineBuf[j] <= lineBuf[j-1];
        nextLbl <= allocNext + CNT_W'(newNeed && canAlloc);
        if (mergeNeed) mergeTab[hiL] <= loL;
        if (pixLbl != '0) begin
          area[pixLbl] <= (frameStart ? '0 : area[pixLbl]) + 1'b1;
          sumX[pixLbl] <= (frameStart ? '0 : sumX[pixLbl]) + SUM_W'(curX);
          sumY[pixLbl] <= (frameStart ? '0 : sumY[pixLbl]) + SUM_W'(curY);
        end
      end
    end
  end

  blob_divider #(.NUM_W(SUM_W), .DEN_W(AREA_W), .OUT_W(XW)) divXInst (
    .clk(clk), .rstN(rstN), .start(ctl.divStart), .num(sumX[idx]),
    .den(area[idx]), .quot(qX), .done(doneX));
  blob_divider #(.NUM_W(SUM_W), .DEN_W(AREA_W), .OUT_W(YW)) divYInst (
    .clk(clk), .rstN(rstN), .start(ctl.divStart), .num(sumY[idx]),
    .den(area[idx]), .quot(qY), .done(doneY));

  assign divDone = doneX;
  assign idxArea = (area[idx] != '0);

  always_comb begin
    if (queryIdx <= LBL_W'(MAX_LABELS)) begin
      queryArea = area[queryIdx];
      queryCx   = cenX[queryIdx];
      queryCy   = cenY[queryIdx];
    end else begin
      queryArea = '0; queryCx = '0; queryCy = '0;
    end
  end

  // R6: both axis dividers finish in the same cycle
  assert_div_lockstep_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneX == doneY);
  // R7: the overflow flag only clears on a frame start
  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !(pixValid && frameStart) |=> overflow);
  // R3: the allocator never runs past one beyond the label limit
  assert_label_cap_R3: assert property (@(posedge clk) disable iff (!rstN)
    nextLbl <= CNT_W'(MAX_LABELS + 1));
endmodule

// File: rtl/blob_labeler.sv
module blob_labeler
  import blob_pkg::*;
#(
  parameter int IMG_W      = 8,
  parameter int IMG_H      = 8,
  parameter int MAX_LABELS = 8,
  parameter int PIX_W      = 12,
  parameter logic [PIX_W-1:0] FG_MIN = 12'h888,
  parameter int LBL_W  = $clog2(MAX_LABELS + 1),
  parameter int XW     = $clog2(IMG_W),
  parameter int YW     = $clog2(IMG_H),
  parameter int AREA_W = $clog2(IMG_W * IMG_H + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  logic [PIX_W-1:0]  pixData,
  input  logic              frameStart,
  input  logic              lineEnd,
  input  logic [LBL_W-1:0]  queryIdx,
  output logic              queryHit,
  output logic [AREA_W-1:0] queryArea,
  output logic [XW-1:0]     queryCx,
  output logic [YW-1:0]     queryCy,
  output logic              resultsReady,
  output logic              labelDone,
  output logic              overflowErr
);
  ctl_t             ctl;
  logic [LBL_W-1:0] idx;
  logic             frameEnd, idxArea, divDone;

  blob_control #(.MAX_LABELS(MAX_LABELS)) ctrlInst (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .frameStart(frameStart),
    .frameEnd(frameEnd), .idxArea(idxArea), .divDone(divDone), .ctl(ctl),
    .idx(idx), .resultsReady(resultsReady), .labelDone(labelDone));

  blob_datapath #(.IMG_W(IMG_W), .IMG_H(IMG_H), .MAX_LABELS(MAX_LABELS),
                  .PIX_W(PIX_W), .FG_MIN(FG_MIN)) dpInst (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixData(pixData),
    .frameStart(frameStart), .lineEnd(lineEnd), .ctl(ctl), .idx(idx),
    .queryIdx(queryIdx), .frameEnd(frameEnd), .idxArea(idxArea),
    .divDone(divDone), .queryArea(queryArea), .queryCx(queryCx),
    .queryCy(queryCy), .overflow(overflowErr));

  assign queryHit = resultsReady && (queryArea != '0);
endmodule

// File: tb/tb_blob_labeler.sv
`timescale 1ns/1ps
module tb_blob_labeler;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixValid = 1'b0;
  logic [11:0] pixData = '0;
  logic        frameStart = 1'b0;
  logic        lineEnd = 1'b0;
  logic [3:0]  queryIdx = '0;
  logic        queryHit, resultsReady, labelDone, overflowErr;
  logic [6:0]  queryArea;
  logic [2:0]  queryCx, queryCy;

  int tests = 0;
  int fails = 0;
  int doneCnt = 0;

  always #4 clk = ~clk;

  blob_labeler dut (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixData(pixData),
    .frameStart(frameStart), .lineEnd(lineEnd), .queryIdx(queryIdx),
    .queryHit(queryHit), .queryArea(queryArea), .queryCx(queryCx),
    .queryCy(queryCy), .resultsReady(resultsReady), .labelDone(labelDone),
    .overflowErr(overflowErr));

  always @(posedge clk) if (labelDone) doneCnt++;

  // mask bit index = y*8 + x ; then expected blob count ; then expected overflow
  localparam logic [68:0] VEC [7] = '{
    {64'h0000000000000000, 4'd0, 1'b0},  // empty
    {64'h0000000020000000, 4'd1, 1'b0},  // single pixel (5,3)
    {64'h0000001E12121200, 4'd1, 1'b0},  // U shape, merge
    {64'h0000000008040201, 4'd4, 1'b0},  // diagonal staircase
    {64'h000000007F555555, 4'd1, 1'b0},  // comb, chained merges
    {64'h800000000000FFFF, 4'd2, 1'b0},  // full-width band plus corner
    {64'h0000000000550055, 4'd8, 1'b0}   // exactly MAX_LABELS labels
  };

  int expArea [9];
  int expSx   [9];
  int expSy   [9];
  int comp    [64];
  int firstPix[9];
  int nNew;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic refModel(input logic [63:0] m);
    nNew = 0;
    for (int l = 0; l < 9; l++) begin firstPix[l] = -1; expArea[l] = 0; expSx[l] = 0; expSy[l] = 0; end
    for (int p = 0; p < 64; p++) begin
      comp[p] = p;
      if (m[p]) begin
        if (!((p % 8 > 0) && m[p-1]) && !((p / 8 > 0) && m[p-8])) begin
          nNew++;
          if (nNew <= 8) firstPix[nNew] = p;
        end
      end
    end
    for (int it = 0; it < 64; it++)
      for (int p = 0; p < 64; p++) if (m[p]) begin
        if (p % 8 > 0 && m[p-1] && comp[p-1] < comp[p]) comp[p] = comp[p-1];
        if (p % 8 < 7 && m[p+1] && comp[p+1] < comp[p]) comp[p] = comp[p+1];
        if (p / 8 > 0 && m[p-8] && comp[p-8] < comp[p]) comp[p] = comp[p-8];
        if (p / 8 < 7 && m[p+8] && comp[p+8] < comp[p]) comp[p] = comp[p+8];
      end
    for (int l = 1; l < 9; l++)
      if (firstPix[l] >= 0 && comp[firstPix[l]] == firstPix[l])
        for (int p = 0; p < 64; p++)
          if (m[p] && comp[p] == firstPix[l]) begin
            expArea[l]++; expSx[l] += p % 8; expSy[l] += p / 8;
          end
  endtask

  task automatic sendFrame(input logic [63:0] m, input logic [11:0] fgData);
    doneCnt = 0;
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 8; x++) begin
        @(negedge clk);
        pixValid   = 1'b1;
        pixData    = m[y*8+x] ? fgData : 12'h000;
        frameStart = (y == 0 && x == 0);
        lineEnd    = (x == 7);
        if (y == 4 && x == 0) check(!resultsReady, "R8", "ready during stream", resultsReady, 0);
      end
    @(negedge clk);
    pixValid = 1'b0; frameStart = 1'b0; lineEnd = 1'b0;
  endtask

  task automatic waitReady();
    int t = 0;
    while (!resultsReady && t < 4000) begin @(negedge clk); t++; end
    check(resultsReady, "R8", "results ready after frame", resultsReady, 1);
  endtask

  task automatic queryLabel(input int l);
    @(negedge clk);
    queryIdx = 4'(l);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=timeout expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    queryIdx = 4'd1;
    #1;
    check(!resultsReady, "R9", "ready after reset", resultsReady, 0);
    check(!overflowErr, "R9", "overflow after reset", overflowErr, 0);
    check(!queryHit, "R9", "query hit after reset", queryHit, 0);
    rstN = 1'b1;

    for (int v = 0; v < 7; v++) begin
      string req;
      req = (v == 2 || v == 4) ? "R4" : (v == 3) ? "R2" : "R5";
      refModel(VEC[v][68:5]);
      sendFrame(VEC[v][68:5], 12'hFFF);
      waitReady();
      check(doneCnt == int'(VEC[v][4:1]), "R8", "labelDone pulses", doneCnt, int'(VEC[v][4:1]));
      check(overflowErr == VEC[v][0], "R7", "overflow flag", overflowErr, VEC[v][0]);
      for (int l = 1; l < 9; l++) begin
        queryLabel(l);
        check(queryHit == (expArea[l] > 0), "R3", "query hit", queryHit, expArea[l] > 0);
        check(int'(queryArea) == expArea[l], req, "area", queryArea, expArea[l]);
        if (expArea[l] > 0) begin
          check(int'(queryCx) == expSx[l] / expArea[l], "R6", "centroid x", queryCx, expSx[l] / expArea[l]);
          check(int'(queryCy) == expSy[l] / expArea[l], "R6", "centroid y", queryCy, expSy[l] / expArea[l]);
        end
      end
    end

    queryLabel(15);
    check(!queryHit, "R3", "index above limit", queryHit, 0);

    // R1: channels exactly at the floor pass
    sendFrame(64'h0000000000040000, 12'h888);
    waitReady();
    queryLabel(1);
    check(queryHit && queryArea == 7'd1, "R1", "pixel at floor", queryArea, 1);
    check(queryCx == 3'd2 && queryCy == 3'd2, "R1", "pixel at floor centroid", queryCx, 2);
    // R1: one channel just below the floor fails
    sendFrame(64'h0000000000040000, 12'h87F);
    waitReady();
    queryLabel(1);
    check(!queryHit, "R1", "green below floor", queryHit, 0);
    sendFrame(64'h0000000000040000, 12'h7FF);
    waitReady();
    queryLabel(1);
    check(!queryHit, "R1", "red below floor", queryHit, 0);

    // R7: checkerboard needs 32 labels
    sendFrame(64'hAA55AA55AA55AA55, 12'hFFF);
    waitReady();
    check(overflowErr, "R7", "overflow on checkerboard", overflowErr, 1);
    // R10: a new frame discards old results and clears the flag
    sendFrame(64'h0, 12'hFFF);
    waitReady();
    check(!overflowErr, "R7", "overflow cleared by frame start", overflowErr, 0);
    for (int l = 1; l < 9; l++) begin
      queryLabel(l);
      check(!queryHit && queryArea == 7'd0, "R10", "stale label after new frame", queryArea, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule